// File: doc/BRIEF.md
# Packed Field Stream Unpacker

The unpacker takes a stream of 32-bit input words in which fixed-width 27-bit fields are laid end to end with no gaps. The first field starts at bit 0 of the first word, and a field may cross a word boundary. The block returns the fields one at a time, each zero-extended to 32 bits. It keeps two buffer words. The low word holds the bits that are ready next. The high word holds the spill from the last fetch that did not fit in the low word. A reserve counter records how many buffered bits are valid.

A job begins when `start` is pulsed in the idle state; `count` gives the number of fields to produce. The controller has three states:

- `ST_IDLE` waits for a job. On `start` it clears the buffers. It moves to `ST_RUN` when `count` is non-zero, and to `ST_DONE` when `count` is zero.
- `ST_RUN` does one of two things each cycle. When fewer than 27 bits are buffered it requests an input word. Otherwise it offers a field. It leaves for `ST_DONE` when the last field is accepted.
- `ST_DONE` lasts one cycle and raises `done`, then returns to `ST_IDLE`.

Both stream sides use valid/ready handshakes.

Top module: `field_unpacker`

## Requirements
- R1: After reset, `in_ready`, `out_valid` and `done` are low, and `in_ready` stays low in the idle state even when `in_valid` is high.
- R2: `start` is sampled only in the idle state. A `start` pulse during a running job has no effect on the number or the values of the fields produced.
- R3: An input word is requested only while fewer than 27 bits are buffered. A job of n fields therefore consumes exactly ceil(27·n/32) input words.
- R4: Input word j supplies stream bits 32·j to 32·j+31, least significant bit first. Output field k equals stream bits 27·k to 27·k+26, with stream bit 27·k at output bit 0.
- R5: Output bits 31:27 are always zero.
- R6: While a field is offered, `in_ready` is low. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value, so no buffered bit is lost.
- R7: A job produces exactly `count` fields and then offers nothing more.
- R8: `done` is high for exactly one cycle, in the cycle after the last field is accepted.
- R9: A job with `count` = 0 produces no field, takes no input, and raises `done` in the cycle after `start`.
- R10: Every job starts with an empty buffer. Bits left over from the last word of the previous job never appear in a later job's fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a job (sampled in idle only) |
| count | input | 16 | Number of fields for the job |
| in_valid | input | 1 | Input word available |
| in_ready | output | 1 | Unit takes the input word this cycle |
| in_data | input | 32 | Packed input word |
| out_valid | output | 1 | Field offered |
| out_ready | input | 1 | Consumer accepts the field |
| out_data | output | 32 | Zero-extended 27-bit field |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
A wrong reserve count shows at the ports within one transfer. The unit either asks for a word too early, so the consumed-word total is off, or it offers a field with misaligned bits. A wrong spill word corrupts the first field that crosses a word boundary, which is at most two fields after the fault. A wrong remaining count shows as a missing or extra field, or as `done` arriving in the wrong cycle. Each of these is caught by comparing every field against values computed from the packed stream, and by counting consumed words and `done` pulses per job.

// File: rtl/field_unpacker_pkg.sv
package field_unpacker_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } unpk_state_e;
endpackage

// File: rtl/field_unpacker_buffer.sv
module field_unpacker_buffer #(
    parameter int IN_W    = 32,
    parameter int FIELD_W = 27,
    parameter int RES_W   = $clog2(IN_W + FIELD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               fetch,
    input  logic               emit,
    input  logic [IN_W-1:0]    in_data,
    output logic [FIELD_W-1:0] field,
    output logic [RES_W-1:0]   reserve,
    output logic               enough
);
    localparam logic [RES_W-1:0] IN_R    = RES_W'(IN_W);
    localparam logic [RES_W-1:0] FIELD_R = RES_W'(FIELD_W);

    logic [IN_W-1:0]   low_q, high_q;
    logic [RES_W-1:0]  res_q;
    logic [2*IN_W-1:0] joined;

    assign joined = {high_q, low_q} >> FIELD_W;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            low_q  <= '0;
            high_q <= '0;
            res_q  <= '0;
        end else if (fetch) begin
            low_q  <= low_q | (in_data << res_q);
            high_q <= (res_q == '0) ? '0 : (in_data >> (IN_R - res_q));
            res_q  <= res_q + IN_R;
        end else if (emit) begin
            low_q  <= joined[IN_W-1:0];
            high_q <= high_q >> FIELD_W;
            res_q  <= res_q - FIELD_R;
        end
    end

    assign field   = low_q[FIELD_W-1:0];
    assign reserve = res_q;
    assign enough  = (res_q >= FIELD_R);
endmodule

// File: rtl/field_unpacker_ctrl.sv
module field_unpacker_ctrl
    import field_unpacker_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic             enough,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             clear,
    output logic             fetch,
    output logic             emit,
    output logic             done
);
    unpk_state_e      state_q;
    logic [CNT_W-1:0] left_q;

    // state register and remaining-field count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    left_q  <= count;
                    state_q <= (count == '0) ? ST_DONE : ST_RUN;
                end
                ST_RUN: if (emit) begin
                    left_q <= left_q - 1'b1;
                    if (left_q == CNT_W'(1)) state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        clear     = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: clear = start;
            ST_RUN: begin
                in_ready  = !enough;
                out_valid = enough;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
        fetch = in_ready && in_valid;
        emit  = out_valid && out_ready;
    end
endmodule

// File: rtl/field_unpacker.sv
module field_unpacker #(
    parameter int IN_W    = 32,
    parameter int FIELD_W = 27,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [IN_W-1:0]  out_data,
    output logic             done
);
    localparam int RES_W = $clog2(IN_W + FIELD_W);

    logic               clear_w, fetch_w, emit_w, enough_w;
    logic [FIELD_W-1:0] field_w;
    logic [RES_W-1:0]   reserve_w;

    field_unpacker_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .count     (count),
        .enough    (enough_w),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .clear     (clear_w),
        .fetch     (fetch_w),
        .emit      (emit_w),
        .done      (done)
    );

    field_unpacker_buffer #(.IN_W(IN_W), .FIELD_W(FIELD_W), .RES_W(RES_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear_w),
        .fetch   (fetch_w),
        .emit    (emit_w),
        .in_data (in_data),
        .field   (field_w),
        .reserve (reserve_w),
        .enough  (enough_w)
    );

    assign out_data = {{(IN_W-FIELD_W){1'b0}}, field_w};
endmodule

// File: rtl/field_unpacker_checker.sv
module field_unpacker_checker #(
    parameter int IN_W    = 32,
    parameter int FIELD_W = 27,
    parameter int RES_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [IN_W-1:0]  out_data,
    input logic             done,
    input logic [RES_W-1:0] reserve
);
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && !in_ready));

    assert_reserve_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(reserve) < (IN_W + FIELD_W));
endmodule

bind field_unpacker field_unpacker_checker #(
    .IN_W(IN_W), .FIELD_W(FIELD_W), .RES_W($clog2(IN_W + FIELD_W))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .done      (done),
    .reserve   (reserve_w)
);

// File: tb/field_unpacker_test.sv
`timescale 1ns/1ps
module field_unpacker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] count = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_count = 0;
    int last_accept = -10;
    logic [31:0] exp_q[$];
    logic [31:0] words[0:63];
    logic        held_v = 1'b0;
    logic [31:0] held_d = '0;

    always #10 clk = ~clk;

    field_unpacker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .count(count),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected fields as the design produces them
    always @(negedge clk) begin
        #2;
        cyc++;
        if (held_v) begin
            check(out_valid && out_data == held_d, "R6 hold under back-pressure", out_data, held_d);
        end
        held_v = out_valid && !out_ready;
        held_d = out_data;
        if (out_valid && out_ready) begin
            last_accept = cyc;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 extra field", out_data, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(out_data == e, "R4 field value", out_data, e);
                check(out_data[31:27] == 5'd0, "R5 upper bits zero", out_data, e);
            end
        end
        if (done) begin
            done_count++;
            check(exp_q.size() == 0, "R7 all fields produced before done", exp_q.size(), 0);
        end
    end

    task automatic run_job(input int n, input int seed, input int mode, input bit mid_start);
        logic [26:0] vals[0:63];
        int nwords, fetched, dc0, it, overlap;
        int acc_at_start;
        nwords = (27 * n + 31) / 32;
        for (int k = 0; k < n; k++) begin
            vals[k] = 27'((seed + k * 32'h9E3779B1) ^ (k << 7));
            exp_q.push_back({5'd0, vals[k]});
        end
        for (int j = 0; j < nwords; j++) begin
            for (int b = 0; b < 32; b++) begin
                int pos;
                pos = 32 * j + b;
                words[j][b] = (pos / 27 < n) ? vals[pos / 27][pos % 27] : 1'b1;
            end
        end
        fetched = 0; overlap = 0; dc0 = done_count; it = 0;
        acc_at_start = last_accept;
        @(negedge clk);
        start = 1'b1; count = 16'(n); in_valid = 1'b0; out_ready = 1'b0;
        while (done_count == dc0 && it < 3000) begin
            @(negedge clk);
            start = (mid_start && it == 3);
            count = mid_start ? 16'd5 : 16'(n);
            it++;
            out_ready = (mode == 1) ? ((it % 3) != 0) : 1'b1;
            in_valid  = (fetched < nwords) && ((mode != 2) || (it % 2 == 0));
            in_data   = (fetched < nwords) ? words[fetched] : 32'hFFFF_FFFF;
            #1;
            if (in_valid && in_ready) fetched++;
            if (in_ready && out_valid) overlap++;
            #2;
        end
        start = 1'b0; in_valid = 1'b0;
        check(it < 3000, "R7 job completes", it, 0);
        check(fetched == nwords, "R3 words consumed", fetched, nwords);
        check(overlap == 0, "R6 no input while field offered", overlap, 0);
        check(done_count == dc0 + 1, "R8 single done pulse", done_count, dc0 + 1);
        if (n == 0) begin
            check(it == 1, "R9 done the cycle after start", it, 1);
            check(last_accept == acc_at_start, "R9 no field for zero count", last_accept, acc_at_start);
        end else begin
            check(cyc == last_accept + 1, "R8 done follows last accept", cyc, last_accept + 1);
        end
        repeat (3) begin
            @(negedge clk); #3;
            check(!out_valid && !done, "R7 quiet after job", {out_valid, done}, 0);
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #3;
        check(!in_ready && !out_valid && !done, "R1 reset outputs low", {in_ready, out_valid, done}, 0);
        rst_n = 1'b1;
        in_valid = 1'b1; in_data = 32'hDEAD_BEEF;
        repeat (2) begin
            @(negedge clk); #3;
            check(!in_ready && !out_valid, "R1 idle ignores input", in_ready, 0);
        end
        in_valid = 1'b0;
        run_job(1, 32'h1234567, 0, 1'b0);
        run_job(5, 32'h0ABCDEF, 0, 1'b0);   // R10: leftover ones from job above
        run_job(32, 32'h5555AAA, 1, 1'b0);  // R6 back-pressure
        run_job(0, 0, 0, 1'b0);             // R9
        run_job(7, 32'h7777777, 0, 1'b1);   // R2 start during run
        run_job(9, 32'h3141592, 2, 1'b0);   // throttled input
        run_job(32, 32'h2718281, 1, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule